// File: doc/BRIEF.md
# Frame-Sync Serial Port SPI Master

This block is an SPI master built in the manner of a synchronous serial port. It does not gate its serial clock or drive a separate chip select. Its serial clock runs freely at half the system clock rate for as long as the port is enabled. An active-low frame sync output serves as the slave select. Slaves on the bus react only to clock edges seen while the select is low, so the clock can keep toggling between words without harm. Running at half the system clock gives twice the bit rate of a master that is held to a quarter of it.

Words to send enter through a one-entry holding register with a valid/ready handshake. `tx_ready` is high while the holding register is empty. A word is taken on any clock edge where `tx_valid` and `tx_ready` are both high. While the register is full, `tx_ready` stays low and the producer must keep `tx_data` and `tx_valid` steady. Nothing is dropped. Each word is shifted out most significant bit first. Framing is late: the select falls together with the first data bit. When the next word is already waiting at the end of a word, the select stays low and the next word follows with no gap. Each received word leaves as a one-cycle pulse on `rx_valid`, with no back-pressure.

Top module: `fsp_spi_master`

## Requirements
- R1: While enabled, `sclk` inverts on every system clock edge, so its period is two system clocks. From reset it is low.
- R2: `sclk` keeps toggling while enabled even when no word is queued and the select is high.
- R3: `sel_n` falls on the same system clock edge on which `sclk` falls. At that point `mosi` already carries bit DATA_W-1 of the word.
- R4: Once `sel_n` is low, it stays low for a whole number of words, DATA_W rising `sclk` edges each.
- R5: If the holding register is full when a word ends, the next word starts at once and `sel_n` stays low. If it is empty, `sel_n` returns high on the falling `sclk` edge after the last bit.
- R6: Words are sent most significant bit first. `mosi` changes only on a falling `sclk` edge.
- R7: `miso` is sampled on each rising `sclk` edge while `sel_n` is low, and the first bit sampled is the most significant. After the last bit, `rx_data` holds the word and `rx_valid` is high for exactly one cycle, the cycle in which `sclk` is high.
- R8: While `sel_n` is high, `mosi` is 0. Clock edges while `sel_n` is high do not disturb the transmit or receive shift state.
- R9: `tx_ready` is high exactly when the holding register is empty. An accepted word makes it low on the next cycle. Under back-pressure no word is lost.
- R10: When `en` drops, the word in progress finishes and no further word starts, not even a merged one. `sclk` then parks low, and a word that is held waits until `en` returns.
- R11: After synchronous reset, `sel_n` is 1, `sclk` is 0, `mosi` is 0, `rx_valid` is 0 and `tx_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Port enable; starts the free-running serial clock |
| tx_data | input | DATA_W | Word to transmit |
| tx_valid | input | 1 | `tx_data` is offered |
| tx_ready | output | 1 | Holding register empty, word will be taken |
| rx_data | output | DATA_W | Last received word |
| rx_valid | output | 1 | One-cycle strobe for `rx_data` |
| sclk | output | 1 | Serial clock, system clock divided by two |
| sel_n | output | 1 | Active-low late frame sync, used as slave select |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The bench builds the block with the default 8-bit word. With words this short, many frames fit into the run: merged bursts, isolated words with idle clocking between them, and words offered while the port is disabled. A bench slave model in SPI mode 0 answers with a computed byte stream. This brings the late-framing instant, the word-boundary merge decision and the enable drop in the middle of a word within reach, each many times under randomized gaps.

// File: rtl/fsp_pkg.sv
package fsp_pkg;
  // Serial clock edge events, valid for the system clock edge that performs them
  typedef struct packed {
    logic rise;
    logic fall;
  } sck_evt_t;
endpackage

// File: rtl/fsp_sck_gen.sv
module fsp_sck_gen
  import fsp_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     en,
  input  logic     frame_busy,
  output logic     sclk,
  output sck_evt_t evt
);
  logic run;
  // keep toggling while enabled, while a word is in flight, or until parked low
  assign run = en | frame_busy | sclk;

  always_ff @(posedge clk) begin
    if (rst)      sclk <= 1'b0;
    else if (run) sclk <= ~sclk;
  end

  assign evt.rise = run & ~sclk;
  assign evt.fall = sclk;

  p_free_run_r2: assert property (@(posedge clk) disable iff (rst)
    en |=> (sclk != $past(sclk)));

  p_park_low_r10: assert property (@(posedge clk) disable iff (rst)
    (!en && !frame_busy && !sclk) |=> !sclk);
endmodule

// File: rtl/fsp_tx_framer.sv
module fsp_tx_framer
  import fsp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  sck_evt_t          evt,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic              busy,
  output logic              samp_en,
  output logic              samp_last,
  output logic              mosi,
  output logic              sel_n
);
  localparam int CW = $clog2(DATA_W + 1);

  logic [DATA_W-1:0] hold_q;
  logic              hold_full;
  logic [DATA_W-1:0] sh_q;
  logic [CW-1:0]     bitcnt;
  logic              word_done;
  logic              take;
  logic              launch;

  assign tx_ready  = ~hold_full;
  assign take      = tx_valid & tx_ready;
  assign word_done = busy & (bitcnt == CW'(DATA_W));
  // a new word may start on a falling edge at a word boundary or from idle
  assign launch    = evt.fall & (word_done | ~busy) & en & hold_full;

  assign samp_en   = evt.rise & busy;
  assign samp_last = samp_en & (bitcnt == CW'(DATA_W - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q    <= '0;
      hold_full <= 1'b0;
    end else if (take) begin
      hold_q    <= tx_data;
      hold_full <= 1'b1;
    end else if (launch) begin
      hold_full <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      sh_q   <= '0;
      bitcnt <= '0;
    end else begin
      if (samp_en) bitcnt <= bitcnt + 1'b1;
      if (evt.fall) begin
        if (launch) begin
          busy   <= 1'b1;
          sh_q   <= hold_q;
          bitcnt <= '0;
        end else if (word_done | ~busy) begin
          busy   <= 1'b0;
        end else begin
          sh_q   <= {sh_q[DATA_W-2:0], 1'b0};
        end
      end
    end
  end

  assign mosi  = busy & sh_q[DATA_W-1];
  assign sel_n = ~busy;

  p_idle_low_r8: assert property (@(posedge clk) disable iff (rst)
    sel_n |-> !mosi);

  p_accept_r9: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_ready) |=> !tx_ready);

  p_word_len_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(sel_n) |-> ($past(bitcnt) == CW'(DATA_W)));
endmodule

// File: rtl/fsp_rx_shift.sv
module fsp_rx_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              samp_en,
  input  logic              samp_last,
  input  logic              miso,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid
);
  logic [DATA_W-1:0] rsh_q;
  logic [DATA_W-1:0] nxt;

  assign nxt = {rsh_q[DATA_W-2:0], miso};

  always_ff @(posedge clk) begin
    if (rst) begin
      rsh_q    <= '0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (samp_en) begin
        rsh_q <= nxt;
        if (samp_last) begin
          rx_data  <= nxt;
          rx_valid <= 1'b1;
        end
      end
    end
  end

  p_one_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);
endmodule

// File: rtl/fsp_spi_master.sv
module fsp_spi_master
  import fsp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              sclk,
  output logic              sel_n,
  output logic              mosi,
  input  logic              miso
);
  sck_evt_t evt;
  logic     busy;
  logic     samp_en;
  logic     samp_last;

  fsp_sck_gen u_sck (
    .clk(clk), .rst(rst), .en(en), .frame_busy(busy),
    .sclk(sclk), .evt(evt)
  );

  fsp_tx_framer #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst(rst), .en(en), .evt(evt),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .busy(busy), .samp_en(samp_en), .samp_last(samp_last),
    .mosi(mosi), .sel_n(sel_n)
  );

  fsp_rx_shift #(.DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst(rst), .samp_en(samp_en), .samp_last(samp_last),
    .miso(miso), .rx_data(rx_data), .rx_valid(rx_valid)
  );

  p_late_frame_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(sel_n) |-> (!sclk && $past(sclk)));

  p_mosi_on_fall_r6: assert property (@(posedge clk) disable iff (rst)
    (mosi != $past(mosi)) |-> (!sclk && $past(sclk)));

  p_strobe_high_r7: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> sclk);
endmodule

// File: tb/sim_fsp_spi_master.sv
module sim_fsp_spi_master;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst, en, tx_valid, miso;
  logic [W-1:0] tx_data;
  logic         tx_ready, rx_valid, sclk, sel_n, mosi;
  logic [W-1:0] rx_data;

  always #2.5 clk = ~clk;

  fsp_spi_master #(.DATA_W(W)) u0 (
    .clk(clk), .rst(rst), .en(en), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid),
    .sclk(sclk), .sel_n(sel_n), .mosi(mosi), .miso(miso)
  );

  int n_chk = 0, n_bad = 0;
  bit done_flag = 0;

  logic [W-1:0] exp_tx [0:511];
  int n_tx = 0;
  int rx_i = 0, rv_i = 0, frames = 0;
  int scnt = 0, mbit = 0, mword = 0;
  logic [W-1:0] cap;
  logic prev_sclk = 1'b0, prev_sel = 1'b1, prev_rv = 1'b0;

  function automatic logic [W-1:0] slave_word(int i);
    int unsigned v;
    v = i * 29 + 83;
    return W'(v ^ (v >> 3));
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // slave model and port monitor
  task automatic slave_step();
    logic [W-1:0] sw;
    if (sclk && !prev_sclk && !sel_n) begin
      cap = {cap[W-2:0], mosi};
      scnt++;
      if (scnt == W) begin
        chk(cap == exp_tx[rx_i], "R6 word on mosi", cap, exp_tx[rx_i]);
        rx_i++;
        scnt = 0;
      end
      mbit++;
      if (mbit == W) begin mbit = 0; mword++; end
      sw = slave_word(mword);
      miso = sw[W-1-mbit];
    end
    if (!sel_n && prev_sel) begin
      frames++;
      chk(!sclk && prev_sclk, "R3 select falls with sclk", sclk, 0);
      chk(mosi == exp_tx[rx_i][W-1], "R3 msb at select fall", mosi, exp_tx[rx_i][W-1]);
    end
    if (sel_n && !prev_sel)
      chk(scnt == 0, "R4 whole words per frame", scnt, 0);
    if (sel_n && mosi)
      chk(0, "R8 mosi idle low", mosi, 0);
    if (rx_valid) begin
      chk(rx_data == slave_word(rv_i), "R7 received word", rx_data, slave_word(rv_i));
      chk(sclk && !prev_rv, "R7 strobe timing", {prev_rv, sclk}, 1);
      rv_i++;
    end
    prev_sclk = sclk;
    prev_sel  = sel_n;
    prev_rv   = rx_valid;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (!rst) slave_step();
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  task automatic push(logic [W-1:0] d);
    tx_data  = d;
    tx_valid = 1'b1;
    exp_tx[n_tx] = d;
    n_tx++;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic wait_done();
    for (int k = 0; k < 4000; k++) begin
      if (rx_i >= n_tx && rv_i >= n_tx) break;
      @(negedge clk);
    end
    chk(rx_i == n_tx, "R6 all words sent", rx_i, n_tx);
    chk(rv_i == n_tx, "R7 all words received", rv_i, n_tx);
  endtask

  initial begin
    logic [W-1:0] sw;
    int f0;
    void'($urandom(32'h1234));
    rst = 1'b1; en = 1'b0; tx_valid = 1'b0; tx_data = '0;
    sw = slave_word(0);
    miso = sw[W-1];
    repeat (4) @(negedge clk);
    chk(sel_n == 1 && sclk == 0 && mosi == 0, "R11 idle pins", {sel_n, sclk, mosi}, 3'b100);
    chk(rx_valid == 0 && tx_ready == 1, "R11 handshake idle", {rx_valid, tx_ready}, 2'b01);
    rst = 1'b0;

    // disabled: clock parked low
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk(sclk == 0, "R1 clock low while disabled", sclk, 0);
    end

    // enabled with no data: free-running half-rate clock
    en = 1'b1;
    @(negedge clk);
    for (int k = 0; k < 20; k++) begin
      logic p;
      p = sclk;
      @(negedge clk);
      chk(sclk != p, "R1 R2 toggles every cycle", sclk, !p);
      chk(sel_n == 1, "R8 no frame without data", sel_n, 1);
    end

    // single word: select returns high when nothing waits
    f0 = frames;
    push(8'hA5);
    wait_done();
    repeat (10) @(negedge clk);
    chk(frames - f0 == 1, "R5 single frame", frames - f0, 1);
    chk(sel_n == 1, "R5 select released", sel_n, 1);

    // back-to-back burst merges into one frame
    f0 = frames;
    push(8'h80); push(8'h01); push(8'hFF); push(8'h00);
    wait_done();
    repeat (6) @(negedge clk);
    chk(frames - f0 == 1, "R5 merged burst", frames - f0, 1);

    // two words separated by idle time give two frames
    f0 = frames;
    push(8'h5A);
    wait_done();
    repeat (13) @(negedge clk);
    push(8'hC3);
    wait_done();
    chk(frames - f0 == 2, "R5 R8 separated frames", frames - f0, 2);

    // disable in mid word
    push(8'h96);
    while (sel_n) @(negedge clk);
    repeat (3) @(negedge clk);
    en = 1'b0;
    wait_done();
    repeat (3) @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      chk(sclk == 0 && sel_n == 1, "R10 clock parks low", {sclk, sel_n}, 2'b01);
    end
    // word offered while disabled is held, not sent
    push(8'h3E);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      chk(sel_n == 1 && tx_ready == 0, "R9 R10 held while disabled", {sel_n, tx_ready}, 2'b10);
    end
    en = 1'b1;
    wait_done();

    // random words with random gaps
    for (int i = 0; i < 60; i++) begin
      push(W'($urandom));
      repeat ($urandom_range(0, 30)) @(negedge clk);
    end
    wait_done();
    // random burst with back-pressure
    f0 = frames;
    for (int i = 0; i < 12; i++) push(W'($urandom));
    wait_done();
    repeat (6) @(negedge clk);
    chk(frames - f0 == 1, "R5 R9 random burst one frame", frames - f0, 1);

    finish_run();
  end
endmodule